// File: doc/BRIEF.md
# Vector Length Narrowing Controller

This block keeps three writable length-limit registers, one for each of the privilege levels 1, 2 and 3, and from them derives the effective scalable-vector length of any privilege level. That length is the number of active 128-bit quadwords minus one. The block also holds a small register file: 32 vector data registers and 17 predicate-style registers. Slots 0 to 15 of the predicate group are the predicates and slot 16 is the first-fault register.

The effective length can shrink in two ways. A limit register can be written with a smaller value, or the privilege level can change, on exception entry or on exception return. When the length shrinks, the block walks the register file one register per cycle. It zeroes every bit above the new active length, so no predicate or data bit beyond that length stays set. While this walk runs, `busy` is high, `ready` is low, and new limit writes and level-change events are ignored. Widening the length never changes stored contents.

The register-file ports let the surrounding logic, or a bench, fill the registers and read them back.

Top module: `vlen_shrink_ctrl`

## Requirements
- R1: Each limit register stores only a 4-bit length field. `cfg_rdata` returns that field in bits [3:0] and zero in bits [63:4]. The select codes are 1, 2 and 3 for levels 1, 2 and 3. Select 0 reads as zero, and a write to select 0 has no effect.
- R2: The effective length of level `cur_el` (0 to 3) starts from MAX_VQ-1 and is lowered by up to three limit registers. The level-1 register applies when the level is 0 or 1. The level-2 register applies when the level is below 2 and `has_el2` is 1. The level-3 register applies when the level is below 3 and `has_el3` is 1.
- R3: Asynchronous reset sets all three limit registers to 4'hF, zeroes the register file and leaves `busy` low.
- R4: A level-change event (`chg_valid`) causes no clearing in two cases: `has_vec` is 0, or `el_fpdis` is set for either the source level or the destination level.
- R5: For change detection, a level counts as length 0 in two cases: its `el_aa64` bit is 0, which means it runs in 32-bit state, or its `el_vtrap` bit is 1.
- R6: Clearing starts only when the new length is strictly smaller than the old one. Widening the length, or keeping it the same, leaves the register file untouched.
- R7: A limit write accepted while `ready` is high compares the effective length of `cur_el` before and after the write. If the length decreased, `busy` is high in the next cycle.
- R8: A clear to length L keeps the low 128*(L+1) bits of each data register and the low 16*(L+1) bits of each of the 17 predicate-group registers. All bits above those are zeroed.
- R9: A clear keeps `busy` high for exactly 49 consecutive cycles. During that time `ready` is low, and limit writes and level-change events are ignored.
- R10: If a limit write and a level-change event both shrink the length in the same cycle, the clear uses the smaller of the two target lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_el | input | 2 | Current privilege level |
| has_vec | input | 1 | Vector extension implemented |
| has_el2 | input | 1 | Level 2 implemented |
| has_el3 | input | 1 | Level 3 implemented |
| el_aa64 | input | 4 | Per level: 1 = 64-bit state |
| el_vtrap | input | 4 | Per level: vector unit trapped |
| el_fpdis | input | 4 | Per level: FP disabled |
| cfg_we | input | 1 | Limit register write strobe |
| cfg_sel | input | 2 | Limit register select (1..3) |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data for `cfg_sel` |
| chg_valid | input | 1 | Level-change event |
| chg_from | input | 2 | Level before the change |
| chg_to | input | 2 | Level after the change |
| ready | output | 1 | Writes and events accepted |
| busy | output | 1 | Clear walk in progress |
| eff_len | output | 4 | Effective length for `cur_el` |
| z_we | input | 1 | Data register write |
| z_idx | input | 5 | Data register index |
| z_wdata | input | 512 | Data register write data |
| z_rdata | output | 512 | Data register read data |
| p_we | input | 1 | Predicate-group write |
| p_idx | input | 5 | Predicate-group index (0..16) |
| p_wdata | input | 64 | Predicate-group write data |
| p_rdata | output | 64 | Predicate-group read data |

## Verification
The bench aims at several traps. At level 2 the level-2 limit must not apply: a design that compares with "at or below" would report a length that is too short. A level in 32-bit state must count as length zero, or a drop from full length would be missed and stale upper bits would survive. Events that arrive with the vector extension absent or FP disabled must be ignored, or data would be wiped when it should not be. A write made during a walk must be dropped, or the limit registers would change under the clear. When a write and an event shrink the length in the same cycle, the smaller target must win, or some bits would be left set. The bench also counts the `busy` cycles, so a walk that is off by one register shows up as a wrong count.

// File: rtl/vlen_pkg.sv
`timescale 1ns/1ps
package vlen_pkg;
  localparam int LEN_W  = 4;
  localparam int CFG_W  = 64;
  localparam int NUM_Z  = 32;
  localparam int NUM_P  = 17;
  localparam logic [LEN_W-1:0] LEN_RST = 4'hF;
  localparam int Q_BITS = 128;
  localparam int P_BITS = 16;
endpackage

// File: rtl/vlen_limit.sv
`timescale 1ns/1ps
module vlen_limit
  import vlen_pkg::*;
#(
  parameter int MAX_VQ = 4
) (
  input  logic [1:0]       el,
  input  logic [LEN_W-1:0] lim1,
  input  logic [LEN_W-1:0] lim2,
  input  logic [LEN_W-1:0] lim3,
  input  logic             has_el2,
  input  logic             has_el3,
  output logic [LEN_W-1:0] len
);
  localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_VQ - 1);

  always_comb begin
    len = CAP;
    if (el <= 2'd1 && lim1 < len) len = lim1;
    if (el < 2'd2 && has_el2 && lim2 < len) len = lim2;
    if (el < 2'd3 && has_el3 && lim3 < len) len = lim3;
  end
endmodule

// File: rtl/vlen_clear_seq.sv
`timescale 1ns/1ps
module vlen_clear_seq
  import vlen_pkg::*;
#(
  parameter int MAX_VQ = 4,
  parameter int NZ     = NUM_Z,
  parameter int NP     = NUM_P
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [LEN_W-1:0]            tgt_len,
  output logic                        busy,
  output logic                        clr_z,
  output logic                        clr_p,
  output logic [$clog2(NZ)-1:0]       clr_zi,
  output logic [$clog2(NP)-1:0]       clr_pi,
  output logic [$clog2(MAX_VQ+1)-1:0] clr_vq
);
  localparam int CW   = $clog2(NZ + NP);
  localparam int ZIW  = $clog2(NZ);
  localparam int PIW  = $clog2(NP);
  localparam int VQW  = $clog2(MAX_VQ + 1);
  localparam logic [CW-1:0] LAST = CW'(NZ + NP - 1);

  logic           busy_q, busy_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [VQW-1:0] vq_q, vq_d;
  logic [CW-1:0]  pofs;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    vq_d   = vq_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        vq_d   = VQW'(tgt_len) + VQW'(1);
      end
    end else if (cnt_q == LAST) begin
      busy_d = 1'b0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      vq_q   <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      vq_q   <= vq_d;
    end
  end

  assign pofs   = cnt_q - CW'(NZ);
  assign busy   = busy_q;
  assign clr_z  = busy_q && (cnt_q < CW'(NZ));
  assign clr_p  = busy_q && (cnt_q >= CW'(NZ));
  assign clr_zi = cnt_q[ZIW-1:0];
  assign clr_pi = pofs[PIW-1:0];
  assign clr_vq = vq_q;

  logic unused_pofs;
  assign unused_pofs = ^pofs;
endmodule

// File: rtl/vlen_regfile.sv
`timescale 1ns/1ps
module vlen_regfile
  import vlen_pkg::*;
#(
  parameter int MAX_VQ = 4,
  parameter int NZ     = NUM_Z,
  parameter int NP     = NUM_P
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        z_we,
  input  logic [$clog2(NZ)-1:0]       z_idx,
  input  logic [MAX_VQ*Q_BITS-1:0]    z_wdata,
  output logic [MAX_VQ*Q_BITS-1:0]    z_rdata,
  input  logic                        p_we,
  input  logic [$clog2(NP)-1:0]       p_idx,
  input  logic [MAX_VQ*P_BITS-1:0]    p_wdata,
  output logic [MAX_VQ*P_BITS-1:0]    p_rdata,
  input  logic                        clr_z,
  input  logic                        clr_p,
  input  logic [$clog2(NZ)-1:0]       clr_zi,
  input  logic [$clog2(NP)-1:0]       clr_pi,
  input  logic [$clog2(MAX_VQ+1)-1:0] clr_vq
);
  localparam int ZW  = MAX_VQ * Q_BITS;
  localparam int PW  = MAX_VQ * P_BITS;
  localparam int VQW = $clog2(MAX_VQ + 1);

  logic [ZW-1:0] zr_q [NZ];
  logic [ZW-1:0] zr_d [NZ];
  logic [PW-1:0] pr_q [NP];
  logic [PW-1:0] pr_d [NP];
  logic [ZW-1:0] zkeep;
  logic [PW-1:0] pkeep;

  for (genvar q = 0; q < MAX_VQ; q++) begin : g_mask
    assign zkeep[q*Q_BITS +: Q_BITS] = {Q_BITS{VQW'(q) < clr_vq}};
    assign pkeep[q*P_BITS +: P_BITS] = {P_BITS{VQW'(q) < clr_vq}};
  end

  always_comb begin
    zr_d = zr_q;
    pr_d = pr_q;
    if (z_we) zr_d[z_idx] = z_wdata;
    if (p_we && (32'(p_idx) < NP)) pr_d[p_idx] = p_wdata;
    if (clr_z) zr_d[clr_zi] = zr_q[clr_zi] & zkeep;
    if (clr_p && (32'(clr_pi) < NP)) pr_d[clr_pi] = pr_q[clr_pi] & pkeep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NZ; i++) zr_q[i] <= '0;
      for (int i = 0; i < NP; i++) pr_q[i] <= '0;
    end else begin
      zr_q <= zr_d;
      pr_q <= pr_d;
    end
  end

  assign z_rdata = zr_q[z_idx];
  assign p_rdata = (32'(p_idx) < NP) ? pr_q[p_idx] : '0;
endmodule

// File: rtl/vlen_shrink_ctrl.sv
`timescale 1ns/1ps
module vlen_shrink_ctrl
  import vlen_pkg::*;
#(
  parameter int MAX_VQ = 4,
  parameter int ZW     = MAX_VQ * 128,
  parameter int PW     = MAX_VQ * 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cur_el,
  input  logic             has_vec,
  input  logic             has_el2,
  input  logic             has_el3,
  input  logic [3:0]       el_aa64,
  input  logic [3:0]       el_vtrap,
  input  logic [3:0]       el_fpdis,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [63:0]      cfg_wdata,
  output logic [63:0]      cfg_rdata,
  input  logic             chg_valid,
  input  logic [1:0]       chg_from,
  input  logic [1:0]       chg_to,
  output logic             ready,
  output logic             busy,
  output logic [3:0]       eff_len,
  input  logic             z_we,
  input  logic [4:0]       z_idx,
  input  logic [ZW-1:0]    z_wdata,
  output logic [ZW-1:0]    z_rdata,
  input  logic             p_we,
  input  logic [4:0]       p_idx,
  input  logic [PW-1:0]    p_wdata,
  output logic [PW-1:0]    p_rdata
);
  localparam int VQW = $clog2(MAX_VQ + 1);

  logic [LEN_W-1:0] r1_q, r2_q, r3_q, r1_d, r2_d, r3_d;
  logic             wr_ok, wr_shrink, chg_shrink, start;
  logic [LEN_W-1:0] len_after, len_from, len_to, det_from, det_to, tgt;
  logic             clr_z, clr_p;
  logic [4:0]       clr_zi, clr_pi;
  logic [VQW-1:0]   clr_vq;

  assign ready = !busy;
  assign wr_ok = cfg_we && ready && (cfg_sel != 2'd0);

  always_comb begin
    r1_d = r1_q;
    r2_d = r2_q;
    r3_d = r3_q;
    if (wr_ok) begin
      case (cfg_sel)
        2'd1:    r1_d = cfg_wdata[LEN_W-1:0];
        2'd2:    r2_d = cfg_wdata[LEN_W-1:0];
        default: r3_d = cfg_wdata[LEN_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q <= LEN_RST;
      r2_q <= LEN_RST;
      r3_q <= LEN_RST;
    end else if (wr_ok) begin
      r1_q <= r1_d;
      r2_q <= r2_d;
      r3_q <= r3_d;
    end
  end

  always_comb begin
    case (cfg_sel)
      2'd1:    cfg_rdata = {{(CFG_W-LEN_W){1'b0}}, r1_q};
      2'd2:    cfg_rdata = {{(CFG_W-LEN_W){1'b0}}, r2_q};
      2'd3:    cfg_rdata = {{(CFG_W-LEN_W){1'b0}}, r3_q};
      default: cfg_rdata = '0;
    endcase
  end

  vlen_limit #(.MAX_VQ(MAX_VQ)) u_cur (.el(cur_el), .lim1(r1_q), .lim2(r2_q), .lim3(r3_q),
    .has_el2(has_el2), .has_el3(has_el3), .len(eff_len));
  vlen_limit #(.MAX_VQ(MAX_VQ)) u_aft (.el(cur_el), .lim1(r1_d), .lim2(r2_d), .lim3(r3_d),
    .has_el2(has_el2), .has_el3(has_el3), .len(len_after));
  vlen_limit #(.MAX_VQ(MAX_VQ)) u_frm (.el(chg_from), .lim1(r1_q), .lim2(r2_q), .lim3(r3_q),
    .has_el2(has_el2), .has_el3(has_el3), .len(len_from));
  vlen_limit #(.MAX_VQ(MAX_VQ)) u_to (.el(chg_to), .lim1(r1_q), .lim2(r2_q), .lim3(r3_q),
    .has_el2(has_el2), .has_el3(has_el3), .len(len_to));

  assign det_from = (el_aa64[chg_from] && !el_vtrap[chg_from]) ? len_from : '0;
  assign det_to   = (el_aa64[chg_to] && !el_vtrap[chg_to]) ? len_to : '0;

  assign wr_shrink  = wr_ok && (len_after < eff_len);
  assign chg_shrink = chg_valid && ready && has_vec && !el_fpdis[chg_from] &&
                      !el_fpdis[chg_to] && (det_to < det_from);
  assign start      = wr_shrink || chg_shrink;

  always_comb begin
    if (wr_shrink && chg_shrink) tgt = (len_after < det_to) ? len_after : det_to;
    else if (wr_shrink)          tgt = len_after;
    else                         tgt = det_to;
  end

  vlen_clear_seq #(.MAX_VQ(MAX_VQ), .NZ(NUM_Z), .NP(NUM_P)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_len(tgt), .busy(busy),
    .clr_z(clr_z), .clr_p(clr_p), .clr_zi(clr_zi), .clr_pi(clr_pi), .clr_vq(clr_vq));

  vlen_regfile #(.MAX_VQ(MAX_VQ), .NZ(NUM_Z), .NP(NUM_P)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .z_we(z_we && ready), .z_idx(z_idx), .z_wdata(z_wdata), .z_rdata(z_rdata),
    .p_we(p_we && ready), .p_idx(p_idx), .p_wdata(p_wdata), .p_rdata(p_rdata),
    .clr_z(clr_z), .clr_p(clr_p), .clr_zi(clr_zi), .clr_pi(clr_pi), .clr_vq(clr_vq));

  logic unused_hi;
  assign unused_hi = ^cfg_wdata[CFG_W-1:LEN_W];
endmodule

// File: rtl/vlen_shrink_ctrl_chk.sv
`timescale 1ns/1ps
module vlen_shrink_ctrl_chk #(
  parameter int MAX_VQ = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        ready,
  input logic        cfg_we,
  input logic        chg_valid,
  input logic        has_vec,
  input logic [63:0] cfg_rdata,
  input logic [3:0]  eff_len,
  input logic [3:0]  r1_q,
  input logic [3:0]  r2_q,
  input logic [3:0]  r3_q
);
  localparam int SPAN = 32 + 17;
  int span_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    span_cnt <= 0;
    else if (busy) span_cnt <= span_cnt + 1;
    else           span_cnt <= 0;
  end

  AST_RAZ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[63:4] == 60'd0); // R1
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    eff_len <= 4'(MAX_VQ - 1)); // R2
  AST_NOVEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_valid && ready && !has_vec && !cfg_we && !busy) |=> !busy); // R4
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (span_cnt == SPAN)); // R9
  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(r1_q) && $stable(r2_q) && $stable(r3_q))); // R9
endmodule

bind vlen_shrink_ctrl vlen_shrink_ctrl_chk #(.MAX_VQ(MAX_VQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ready(ready), .cfg_we(cfg_we),
  .chg_valid(chg_valid), .has_vec(has_vec), .cfg_rdata(cfg_rdata),
  .eff_len(eff_len), .r1_q(r1_q), .r2_q(r2_q), .r3_q(r3_q));

// File: tb/sim_vlen_shrink_ctrl.sv
`timescale 1ns/1ps
module sim_vlen_shrink_ctrl;
  localparam int ZW = 512;
  localparam int PW = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cur_el;
  logic has_vec, has_el2, has_el3;
  logic [3:0] el_aa64, el_vtrap, el_fpdis;
  logic cfg_we;
  logic [1:0] cfg_sel;
  logic [63:0] cfg_wdata, cfg_rdata;
  logic chg_valid;
  logic [1:0] chg_from, chg_to;
  logic ready, busy;
  logic [3:0] eff_len;
  logic z_we, p_we;
  logic [4:0] z_idx, p_idx;
  logic [ZW-1:0] z_wdata, z_rdata;
  logic [PW-1:0] p_wdata, p_rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  vlen_shrink_ctrl u0 (.*);

  // {el, lim1, lim2, lim3, has_el2, has_el3, expected length}
  localparam logic [19:0] TBL [8] = '{
    {2'd0, 4'h2, 4'hF, 4'hF, 1'b1, 1'b1, 4'd2},
    {2'd1, 4'hF, 4'h1, 4'hF, 1'b1, 1'b1, 4'd1},
    {2'd1, 4'hF, 4'h1, 4'hF, 1'b0, 1'b1, 4'd3},
    {2'd2, 4'h0, 4'hF, 4'h2, 1'b1, 1'b1, 4'd2},
    {2'd2, 4'h0, 4'hF, 4'h2, 1'b1, 1'b0, 4'd3},
    {2'd3, 4'h0, 4'h0, 4'h0, 1'b1, 1'b1, 4'd3},
    {2'd0, 4'hF, 4'hF, 4'h0, 1'b1, 1'b1, 4'd0},
    {2'd2, 4'hF, 4'h1, 4'hF, 1'b1, 1'b1, 4'd3}
  };

  function automatic logic [ZW-1:0] zkeep(int vq);
    logic [ZW-1:0] r;
    for (int i = 0; i < ZW; i++) r[i] = (i < 128 * vq);
    return r;
  endfunction

  function automatic logic [PW-1:0] pkeep(int vq);
    logic [PW-1:0] r;
    for (int i = 0; i < PW; i++) r[i] = (i < 16 * vq);
    return r;
  endfunction

  task automatic check(string req, logic [ZW-1:0] act, logic [ZW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(logic [1:0] sel, logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic chg(logic [1:0] f, logic [1:0] t);
    @(negedge clk);
    chg_valid = 1'b1; chg_from = f; chg_to = t;
    @(negedge clk);
    chg_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic fill_all();
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); z_we = 1'b1; z_idx = 5'(i); z_wdata = '1;
    end
    @(negedge clk); z_we = 1'b0;
    for (int i = 0; i < 17; i++) begin
      @(negedge clk); p_we = 1'b1; p_idx = 5'(i); p_wdata = '1;
    end
    @(negedge clk); p_we = 1'b0;
  endtask

  task automatic fill_one();
    @(negedge clk); z_we = 1'b1; z_idx = 5'd5; z_wdata = '1;
    p_we = 1'b1; p_idx = 5'd3; p_wdata = '1;
    @(negedge clk); z_we = 1'b0; p_we = 1'b0;
  endtask

  task automatic rd_z(int i, output logic [ZW-1:0] v);
    z_idx = 5'(i); #1; v = z_rdata;
  endtask

  task automatic rd_p(int i, output logic [PW-1:0] v);
    p_idx = 5'(i); #1; v = p_rdata;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [ZW-1:0] zv;
    logic [PW-1:0] pv;
    int n;
    rst_n = 1'b0; cur_el = 2'd3; has_vec = 1'b1; has_el2 = 1'b1; has_el3 = 1'b1;
    el_aa64 = 4'hF; el_vtrap = 4'h0; el_fpdis = 4'h0;
    cfg_we = 1'b0; cfg_sel = 2'd1; cfg_wdata = '0;
    chg_valid = 1'b0; chg_from = 2'd0; chg_to = 2'd0;
    z_we = 1'b0; p_we = 1'b0; z_idx = '0; p_idx = '0; z_wdata = '0; p_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state
    check("R3 busy", ZW'(busy), '0);
    check("R3 ready", ZW'(ready), ZW'(1));
    cfg_sel = 2'd1; #1;
    check("R3 lim1", ZW'(cfg_rdata), ZW'(64'hF));
    cur_el = 2'd0; #1;
    check("R3 eff_len", ZW'(eff_len), ZW'(3));
    rd_z(7, zv);
    check("R3 zreg", zv, '0);
    rd_p(16, pv);
    check("R3 preg", ZW'(pv), '0);
    cur_el = 2'd3;

    // R2 table walk
    foreach (TBL[k]) begin
      cur_el = 2'd3;
      cfg_wr(2'd1, 64'(TBL[k][17:14]));
      cfg_wr(2'd2, 64'(TBL[k][13:10]));
      cfg_wr(2'd3, 64'(TBL[k][9:6]));
      wait_idle();
      @(negedge clk);
      cur_el = TBL[k][19:18]; has_el2 = TBL[k][5]; has_el3 = TBL[k][4];
      #1;
      check($sformatf("R2 row %0d", k), ZW'(eff_len), ZW'(TBL[k][3:0]));
    end
    cur_el = 2'd3; has_el2 = 1'b1; has_el3 = 1'b1;

    // R1 field width and select 0
    cfg_wr(2'd1, 64'hFFFF_FFFF_FFFF_FFF5);
    cfg_sel = 2'd1; #1;
    check("R1 high bits", ZW'(cfg_rdata), ZW'(64'h5));
    cfg_wr(2'd0, 64'h1);
    cfg_sel = 2'd0; #1;
    check("R1 sel0 reads zero", ZW'(cfg_rdata), '0);
    cfg_sel = 2'd1; #1;
    check("R1 sel0 no effect", ZW'(cfg_rdata), ZW'(64'h5));

    cfg_wr(2'd1, 64'hF); cfg_wr(2'd2, 64'hF); cfg_wr(2'd3, 64'hF);

    // R7/R8/R9 write narrowing from length 3 to 1
    fill_all();
    cur_el = 2'd1;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 64'h1;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R7 busy after shrink write", ZW'(busy), ZW'(1));
    check("R9 ready low", ZW'(ready), '0);
    n = 1;
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 64'h0;
    @(negedge clk);
    cfg_we = 1'b0;
    while (busy) begin n++; @(negedge clk); end
    check("R9 busy cycles", ZW'(n), ZW'(49));
    cfg_sel = 2'd2; #1;
    check("R9 write ignored", ZW'(cfg_rdata), ZW'(64'hF));
    rd_z(0, zv);  check("R8 z0", zv, zkeep(2));
    rd_z(31, zv); check("R8 z31", zv, zkeep(2));
    rd_p(0, pv);  check("R8 p0", ZW'(pv), ZW'(pkeep(2)));
    rd_p(16, pv); check("R8 first-fault", ZW'(pv), ZW'(pkeep(2)));
    check("R7 eff_len", ZW'(eff_len), ZW'(1));

    // R6 widen and equal
    cfg_wr(2'd1, 64'h3);
    check("R6 widen no busy", ZW'(busy), '0);
    cfg_wr(2'd1, 64'h3);
    check("R6 equal no busy", ZW'(busy), '0);
    check("R6 eff_len", ZW'(eff_len), ZW'(3));
    rd_z(31, zv); check("R6 contents kept", zv, zkeep(2));

    // R4 gating of level changes
    cur_el = 2'd3;
    cfg_wr(2'd1, 64'h0);
    fill_one();
    has_vec = 1'b0;
    chg(2'd3, 2'd0);
    check("R4 no vec no busy", ZW'(busy), '0);
    rd_z(5, zv); check("R4 no vec kept", zv, '1);
    has_vec = 1'b1; el_fpdis = 4'b0001;
    chg(2'd3, 2'd0);
    check("R4 fp off no busy", ZW'(busy), '0);
    el_fpdis = 4'b1000;
    chg(2'd3, 2'd0);
    check("R4 fp off source no busy", ZW'(busy), '0);
    el_fpdis = 4'h0;
    chg(2'd3, 2'd0);
    check("R4 enabled busy", ZW'(busy), ZW'(1));
    wait_idle();
    rd_z(5, zv); check("R8 z5 len0", zv, zkeep(1));
    rd_p(3, pv); check("R8 p3 len0", ZW'(pv), ZW'(pkeep(1)));

    // R5 32-bit state and trapped levels count as zero
    cfg_wr(2'd1, 64'hF);
    fill_one();
    el_aa64 = 4'b1101;
    chg(2'd3, 2'd1);
    check("R5 aa32 target busy", ZW'(busy), ZW'(1));
    wait_idle();
    rd_z(5, zv); check("R5 aa32 clear", zv, zkeep(1));
    el_aa64 = 4'hF;
    fill_one();
    el_vtrap = 4'b0010;
    chg(2'd1, 2'd3);
    check("R5 trapped source no busy", ZW'(busy), '0);
    rd_z(5, zv); check("R5 trapped kept", zv, '1);
    el_vtrap = 4'h0;

    // R10 simultaneous write and level change
    cur_el = 2'd3;
    cfg_wr(2'd1, 64'h2);
    fill_one();
    cur_el = 2'd1;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 64'h0;
    chg_valid = 1'b1; chg_from = 2'd3; chg_to = 2'd1;
    @(negedge clk);
    cfg_we = 1'b0; chg_valid = 1'b0;
    check("R10 busy", ZW'(busy), ZW'(1));
    wait_idle();
    rd_z(5, zv); check("R10 smaller target", zv, zkeep(1));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule